// File: doc/BRIEF.md
# Banked-Register Trap Entry Sequencer

This block holds the architectural integer state of a 32-bit core: two banks of sixteen general registers (one for user mode, one for supervisor mode), the program counter, a processor status word and a system status word. The core reads and writes registers through a plain port, and the system status word's mode bit picks the bank. Register 15 of each bank is that mode's stack pointer.

When an interrupt request arrives at an instruction boundary while interrupts are enabled, a multi-cycle sequencer takes over. It pushes the program counter, then the processor status word, then the system status word onto the stack of the bank that was active before entry. It clears the processor status word. It then reads the new program counter and the new system status word from a two-word trap vector in memory and signals completion. From that point on the register bank follows the mode bit of the reloaded system status word.

All stack and vector traffic uses one memory port with a valid/ready handshake. The sequencer raises `mem_valid` and holds the address, direction and write data steady until `mem_ready` is sampled high at a clock edge. The memory may apply back-pressure for any number of cycles by holding `mem_ready` low. Read data is taken in the cycle where valid and ready are both high. The block never withdraws a request it has raised.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the program counter equals the RESET_PC parameter (default 0), the processor status word and system status word are 0, all registers in both banks read 0, and `busy`, `done` and `mem_valid` are low.
- R2: System status word bit 1 selects the register bank for core reads and writes (1 = user, 0 = supervisor). A value written in one bank does not show in the other.
- R3: A request is accepted on a clock edge where `irq_req`, `at_boundary` and system status word bit 0 (interrupt enable) are all high and the sequencer is idle. `busy` is high from the next cycle. Otherwise no memory access starts and `busy` stays low.
- R4: Entry performs three writes in this order: program counter, processor status word, system status word. Each write goes to the address held in register 15 minus 4, and that register is then decremented by 4. Register 15 belongs to the bank selected before entry, so that register ends 12 lower.
- R5: After the three saves the processor status word is 0, and it is still 0 when `done` is high.
- R6: Entry then reads two words: the new program counter from VEC_BASE + 8 × irq number, then the new system status word from that address + 4. The values read become the program counter and the system status word.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` keep their values into the next cycle. Any stall length completes correctly.
- R8: `done` is high for exactly one cycle: the cycle right after the edge on which the second vector word is taken. `busy` falls in the cycle after that.
- R9: While `busy` is high, further requests are ignored. Core writes to registers, program counter, processor status word and system status word are dropped during this time, and also in the cycle of acceptance.
- R10: After entry, core register reads and writes use the bank named by bit 1 of the reloaded system status word. The other bank keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request level |
| irq_num | input | IRQ_W | Interrupt number, sampled at acceptance |
| at_boundary | input | 1 | High when the core is at an instruction boundary |
| rf_raddr | input | 4 | Core register read index |
| rf_rdata | output | 32 | Register read data from the active bank |
| rf_we | input | 1 | Core register write enable |
| rf_waddr | input | 4 | Core register write index |
| rf_wdata | input | 32 | Core register write data |
| pc_we | input | 1 | Core program counter write enable |
| pc_wdata | input | 32 | Core program counter write data |
| psw_we | input | 1 | Core processor status word write enable |
| psw_wdata | input | 32 | Core processor status word write data |
| ssw_we | input | 1 | Core system status word write enable |
| ssw_wdata | input | 32 | Core system status word write data |
| pc | output | 32 | Current program counter |
| psw | output | 32 | Current processor status word |
| ssw | output | 32 | Current system status word |
| busy | output | 1 | Trap entry in progress |
| done | output | 1 | One-cycle entry completion pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts/completes request |
| mem_write | output | 1 | 1 = write (push), 0 = read (vector) |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, taken when valid and ready are high |

## Verification
A wrong bank choice at entry shows at the first stack write. Its address is derived from the wrong register 15, and the mismatch is visible in the same cycle the write is offered. A wrong sequencer state shows as a push out of order or a missing vector read at the very next handshake, or as `done` appearing in the wrong cycle. A corrupted stack pointer update stays hidden until later. It shows at the second or third push address, or at the final register 15 read back in the old bank after entry. A failure to drop core writes during entry shows in the pushed data while a request is stalled, in the final program counter, or in a register read afterwards.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_PUSH_PSW,
    ST_PUSH_SSW,
    ST_LOAD_PC,
    ST_LOAD_SSW,
    ST_DONE
  } trap_state_e;

  localparam int SSW_IE_BIT   = 0;
  localparam int SSW_USER_BIT = 1;
endpackage

// File: rtl/trap_regbank.sv
module trap_regbank #(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  parameter int NBANK  = 2,
  parameter int SP_IDX = 15,
  localparam int ADDR_W = $clog2(NREG),
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BANK_W-1:0] sp_bank,
  output logic [DATA_W-1:0] sp_rdata,
  input  logic              sp_we,
  input  logic [DATA_W-1:0] sp_wdata
);
  logic [DATA_W-1:0] bank_rd [NBANK];
  logic [DATA_W-1:0] bank_sp [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DATA_W-1:0] regs_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      end else begin
        if (wr_en && wr_bank == BANK_W'(b)) regs_q[wr_addr] <= wr_data;
        if (sp_we && sp_bank == BANK_W'(b)) regs_q[SP_IDX] <= sp_wdata;
      end
    end

    assign bank_rd[b] = regs_q[rd_addr];
    assign bank_sp[b] = regs_q[SP_IDX];
  end

  assign rd_data  = bank_rd[rd_bank];
  assign sp_rdata = bank_sp[sp_bank];
endmodule

// File: rtl/trap_status.sv
module trap_status #(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_pc_we,
  input  logic [DATA_W-1:0] core_pc_wd,
  input  logic              core_psw_we,
  input  logic [DATA_W-1:0] core_psw_wd,
  input  logic              core_ssw_we,
  input  logic [DATA_W-1:0] core_ssw_wd,
  input  logic              psw_clear,
  input  logic              pc_load,
  input  logic              ssw_load,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] pc_q,
  output logic [DATA_W-1:0] psw_q,
  output logic [DATA_W-1:0] ssw_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= DATA_W'(RESET_PC);
      psw_q <= '0;
      ssw_q <= '0;
    end else begin
      if (pc_load)          pc_q <= load_data;
      else if (core_pc_we)  pc_q <= core_pc_wd;

      if (psw_clear)        psw_q <= '0;
      else if (core_psw_we) psw_q <= core_psw_wd;

      if (ssw_load)         ssw_q <= load_data;
      else if (core_ssw_we) ssw_q <= core_ssw_wd;
    end
  end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          IRQ_W    = 4,
  parameter logic [31:0] VEC_BASE = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [IRQ_W-1:0]  irq_num,
  input  logic              at_boundary,
  input  logic              ie,
  input  logic              mode,
  input  logic [DATA_W-1:0] pc_val,
  input  logic [DATA_W-1:0] psw_val,
  input  logic [DATA_W-1:0] ssw_val,
  input  logic [DATA_W-1:0] sp_val,
  output logic              entry_bank,
  output logic              sp_we,
  output logic [DATA_W-1:0] sp_wdata,
  output logic              psw_clear,
  output logic              pc_load,
  output logic              ssw_load,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(4);

  trap_state_e       state_q, state_d;
  logic [IRQ_W-1:0]  irq_q;
  logic [DATA_W-1:0] vec_addr;
  logic [DATA_W-1:0] sp_next;
  logic              xfer;
  logic              is_push;

  assign accept   = (state_q == ST_IDLE) && irq_req && at_boundary && ie;
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign is_push  = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_PSW) ||
                    (state_q == ST_PUSH_SSW);
  assign mem_valid = is_push || (state_q == ST_LOAD_PC) || (state_q == ST_LOAD_SSW);
  assign mem_write = is_push;
  assign xfer     = mem_valid && mem_ready;
  assign sp_next  = sp_val - WORD_BYTES;
  assign vec_addr = DATA_W'(VEC_BASE) + (DATA_W'(irq_q) << 3);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      ST_PUSH_PC:  begin mem_addr = sp_next; mem_wdata = pc_val;  end
      ST_PUSH_PSW: begin mem_addr = sp_next; mem_wdata = psw_val; end
      ST_PUSH_SSW: begin mem_addr = sp_next; mem_wdata = ssw_val; end
      ST_LOAD_PC:  mem_addr = vec_addr;
      ST_LOAD_SSW: mem_addr = vec_addr + WORD_BYTES;
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (accept) state_d = ST_PUSH_PC;
      ST_PUSH_PC:  if (xfer)   state_d = ST_PUSH_PSW;
      ST_PUSH_PSW: if (xfer)   state_d = ST_PUSH_SSW;
      ST_PUSH_SSW: if (xfer)   state_d = ST_LOAD_PC;
      ST_LOAD_PC:  if (xfer)   state_d = ST_LOAD_SSW;
      ST_LOAD_SSW: if (xfer)   state_d = ST_DONE;
      ST_DONE:                 state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  assign sp_we     = is_push && xfer;
  assign sp_wdata  = sp_next;
  assign psw_clear = (state_q == ST_PUSH_SSW) && xfer;
  assign pc_load   = (state_q == ST_LOAD_PC) && xfer;
  assign ssw_load  = (state_q == ST_LOAD_SSW) && xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      irq_q      <= '0;
      entry_bank <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        irq_q      <= irq_num;
        entry_bank <= mode;
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
      $stable(mem_write) && $stable(mem_wdata))); // R7

  AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD_SSW && mem_ready) |=> done); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R8

  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |=> (sp_val == $past(sp_val) - WORD_BYTES)); // R4
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          NREG     = 16,
  parameter int          IRQ_W    = 4,
  parameter logic [31:0] VEC_BASE = 32'h0000_1000,
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  localparam int         RA_W     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [IRQ_W-1:0]  irq_num,
  input  logic              at_boundary,
  input  logic [RA_W-1:0]   rf_raddr,
  output logic [DATA_W-1:0] rf_rdata,
  input  logic              rf_we,
  input  logic [RA_W-1:0]   rf_waddr,
  input  logic [DATA_W-1:0] rf_wdata,
  input  logic              pc_we,
  input  logic [DATA_W-1:0] pc_wdata,
  input  logic              psw_we,
  input  logic [DATA_W-1:0] psw_wdata,
  input  logic              ssw_we,
  input  logic [DATA_W-1:0] ssw_wdata,
  output logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] psw,
  output logic [DATA_W-1:0] ssw,
  output logic              busy,
  output logic              done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              accept;
  logic              core_ok;
  logic              entry_bank;
  logic              sp_we;
  logic [DATA_W-1:0] sp_wdata;
  logic [DATA_W-1:0] sp_val;
  logic              psw_clear, pc_load, ssw_load;
  logic              cur_bank;

  assign core_ok  = !busy && !accept;
  assign cur_bank = ssw[SSW_USER_BIT];

  trap_regbank #(
    .DATA_W (DATA_W),
    .NREG   (NREG),
    .NBANK  (2),
    .SP_IDX (NREG - 1)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_bank  (cur_bank),
    .rd_addr  (rf_raddr),
    .rd_data  (rf_rdata),
    .wr_en    (rf_we && core_ok),
    .wr_bank  (cur_bank),
    .wr_addr  (rf_waddr),
    .wr_data  (rf_wdata),
    .sp_bank  (entry_bank),
    .sp_rdata (sp_val),
    .sp_we    (sp_we),
    .sp_wdata (sp_wdata)
  );

  trap_status #(
    .DATA_W   (DATA_W),
    .RESET_PC (RESET_PC)
  ) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_pc_we  (pc_we && core_ok),
    .core_pc_wd  (pc_wdata),
    .core_psw_we (psw_we && core_ok),
    .core_psw_wd (psw_wdata),
    .core_ssw_we (ssw_we && core_ok),
    .core_ssw_wd (ssw_wdata),
    .psw_clear   (psw_clear),
    .pc_load     (pc_load),
    .ssw_load    (ssw_load),
    .load_data   (mem_rdata),
    .pc_q        (pc),
    .psw_q       (psw),
    .ssw_q       (ssw)
  );

  trap_ctrl #(
    .DATA_W   (DATA_W),
    .IRQ_W    (IRQ_W),
    .VEC_BASE (VEC_BASE)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .irq_num     (irq_num),
    .at_boundary (at_boundary),
    .ie          (ssw[SSW_IE_BIT]),
    .mode        (cur_bank),
    .pc_val      (pc),
    .psw_val     (psw),
    .ssw_val     (ssw),
    .sp_val      (sp_val),
    .entry_bank  (entry_bank),
    .sp_we       (sp_we),
    .sp_wdata    (sp_wdata),
    .psw_clear   (psw_clear),
    .pc_load     (pc_load),
    .ssw_load    (ssw_load),
    .accept      (accept),
    .busy        (busy),
    .done        (done),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_write   (mem_write),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata)
  );

  AST_ACCEPT_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(irq_req && at_boundary && ssw[SSW_IE_BIT])); // R3

  AST_PSW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (psw == '0)); // R5

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (!mem_valid)); // R3
endmodule

// File: tb/trap_entry_seq_test.sv
`timescale 1ns/1ps
module trap_entry_seq_test;
  localparam logic [31:0] VBASE = 32'h0000_1000;

  typedef struct packed {
    logic        w;
    logic [31:0] a;
    logic [31:0] d;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic [3:0]  irq_num = '0;
  logic        at_boundary = 1'b0;
  logic [3:0]  rf_raddr = '0;
  logic [31:0] rf_rdata;
  logic        rf_we = 1'b0;
  logic [3:0]  rf_waddr = '0;
  logic [31:0] rf_wdata = '0;
  logic        pc_we = 1'b0;
  logic [31:0] pc_wdata = '0;
  logic        psw_we = 1'b0;
  logic [31:0] psw_wdata = '0;
  logic        ssw_we = 1'b0;
  logic [31:0] ssw_wdata = '0;
  logic [31:0] pc, psw, ssw;
  logic        busy, done;
  logic        mem_valid, mem_write;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int          n_chk = 0;
  int          n_fail = 0;
  int          stall_cfg = 0;
  int          wait_cnt = 0;
  int          cycles = 0;
  logic [31:0] vec_ssw = '0;
  logic        final_hs = 1'b0;
  item_t       exp_q[$];

  always #5 clk = ~clk;

  trap_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_num(irq_num),
    .at_boundary(at_boundary), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .psw_we(psw_we), .psw_wdata(psw_wdata),
    .ssw_we(ssw_we), .ssw_wdata(ssw_wdata), .pc(pc), .psw(psw), .ssw(ssw),
    .busy(busy), .done(done), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem_addr[2] ? vec_ssw : (32'h4000_0000 | mem_addr);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: memory responder, scoreboard pop and done timing
  always @(negedge clk) begin
    if (rst_n) begin
      if (done || final_hs) chk("R8 done timing", {31'b0, done}, {31'b0, final_hs});
      final_hs = 1'b0;
      if (mem_valid) begin
        if (wait_cnt >= stall_cfg) begin
          mem_ready = 1'b1;
          wait_cnt = 0;
          if (exp_q.size() == 0) begin
            chk("R3 unexpected access", mem_addr, 32'hFFFF_FFFF);
          end else begin
            item_t e;
            e = exp_q.pop_front();
            chk("R4/R6 access dir", {31'b0, mem_write}, {31'b0, e.w});
            chk("R4/R6 access addr", mem_addr, e.a);
            if (e.w) chk("R4 push data", mem_wdata, e.d);
          end
          final_hs = !mem_write && mem_addr[2];
        end else begin
          mem_ready = 1'b0;
          wait_cnt++;
        end
      end else begin
        mem_ready = 1'b0;
        wait_cnt = 0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    rf_we = 1'b1; rf_waddr = a; rf_wdata = d;
    @(negedge clk); rf_we = 1'b0;
  endtask

  task automatic wr_ssw(logic [31:0] d);
    ssw_we = 1'b1; ssw_wdata = d;
    @(negedge clk); ssw_we = 1'b0;
  endtask

  task automatic wr_pc_psw(logic [31:0] p, logic [31:0] s);
    pc_we = 1'b1; pc_wdata = p; psw_we = 1'b1; psw_wdata = s;
    @(negedge clk); pc_we = 1'b0; psw_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] exp);
    rf_raddr = a; #1;
    chk(tag, rf_rdata, exp);
  endtask

  // driver: queue the expected accesses, then raise the request
  task automatic do_trap(logic [3:0] num, logic [31:0] sp, logic [31:0] pcv,
                         logic [31:0] pswv, logic [31:0] sswv,
                         logic [31:0] new_ssw, int stall, bit disturb);
    logic [31:0] va;
    va = VBASE + {24'b0, num, 3'b000};
    exp_q.push_back('{1'b1, sp - 32'd4,  pcv});
    exp_q.push_back('{1'b1, sp - 32'd8,  pswv});
    exp_q.push_back('{1'b1, sp - 32'd12, sswv});
    exp_q.push_back('{1'b0, va, 32'h0});
    exp_q.push_back('{1'b0, va + 32'd4, 32'h0});
    vec_ssw = new_ssw;
    stall_cfg = stall;
    irq_req = 1'b1; irq_num = num; at_boundary = 1'b1;
    @(negedge clk); #1;
    chk("R3 busy after accept", {31'b0, busy}, 32'd1);
    if (disturb) begin
      rf_we = 1'b1; rf_waddr = 4'd3; rf_wdata = 32'h0000_0BAD;
      pc_we = 1'b1; pc_wdata = 32'h0000_0BAD;
    end
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); #1;
      if (done) break;
    end
    rf_we = 1'b0; pc_we = 1'b0;
    irq_req = 1'b0; at_boundary = 1'b0;
    @(negedge clk); #1;
    chk("R6 all accesses made", exp_q.size(), 32'd0);
    chk("R8 busy falls", {31'b0, busy}, 32'd0);
    chk("R6 new pc", pc, 32'h4000_0000 | va);
    chk("R6 new ssw", ssw, new_ssw);
    chk("R5 psw cleared", psw, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 pc reset", pc, 32'h0);
    chk("R1 psw reset", psw, 32'h0);
    chk("R1 ssw reset", ssw, 32'h0);
    chk("R1 busy/done/valid reset", {29'b0, busy, done, mem_valid}, 32'h0);
    rd_chk("R1 reg reset", 4'd15, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: separate banks
    wr_reg(4'd15, 32'h0000_8000);
    wr_reg(4'd3,  32'h0000_5555);
    wr_ssw(32'h0000_0002);
    wr_reg(4'd15, 32'h0000_9000);
    wr_reg(4'd3,  32'h0000_3333);
    rd_chk("R2 user bank r3", 4'd3, 32'h0000_3333);
    wr_ssw(32'h0000_0000);
    rd_chk("R2 supervisor bank r3", 4'd3, 32'h0000_5555);

    // R3: enable low, then boundary low
    wr_ssw(32'h0000_0002);
    irq_req = 1'b1; at_boundary = 1'b1;
    repeat (4) @(negedge clk);
    #1; chk("R3 ignored when disabled", {31'b0, busy}, 32'd0);
    at_boundary = 1'b0;
    wr_ssw(32'h0000_0003);
    repeat (4) @(negedge clk);
    #1; chk("R3 ignored off boundary", {31'b0, busy}, 32'd0);
    irq_req = 1'b0;
    @(negedge clk);

    // entry from user mode, no stalls, core writes attempted while busy
    wr_pc_psw(32'h0000_0100, 32'hDEAD_BEEF);
    wr_ssw(32'h0000_0F03);
    do_trap(4'd3, 32'h0000_9000, 32'h0000_0100, 32'hDEAD_BEEF, 32'h0000_0F03,
            32'h0000_0004, 0, 1'b1);
    rd_chk("R10 supervisor sp after entry", 4'd15, 32'h0000_8000);
    rd_chk("R10 supervisor r3 kept", 4'd3, 32'h0000_5555);
    wr_ssw(32'h0000_0002);
    rd_chk("R4 user sp lowered by 12", 4'd15, 32'h0000_8FF4);
    rd_chk("R9 user r3 write dropped", 4'd3, 32'h0000_3333);

    // entry from supervisor mode, stalled handshakes, highest vector
    wr_ssw(32'h0000_0001);
    wr_pc_psw(32'h0000_0200, 32'h1234_5678);
    do_trap(4'd15, 32'h0000_8000, 32'h0000_0200, 32'h1234_5678, 32'h0000_0001,
            32'h0000_0003, 2, 1'b1);
    rd_chk("R10 user bank after entry", 4'd15, 32'h0000_8FF4);
    repeat (3) @(negedge clk);
    #1; chk("R9 no re-entry after done", {31'b0, busy}, 32'd0);

    // entry from user mode, one-cycle stalls, vector zero
    wr_pc_psw(32'h0000_0300, 32'hFFFF_FFFF);
    do_trap(4'd0, 32'h0000_8FF4, 32'h0000_0300, 32'hFFFF_FFFF, 32'h0000_0003,
            32'h0000_0000, 1, 1'b0);
    rd_chk("R10 supervisor sp lowered", 4'd15, 32'h0000_7FF4);
    wr_ssw(32'h0000_0002);
    rd_chk("R4 user sp after third entry", 4'd15, 32'h0000_8FE8);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule